// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block moves one PLL from its current divisor setting to a new one without letting any consumer see an unstable clock. A one-cycle start request brings in three divisor values: the reference divider NR, the feedback multiplier NF and the output divider NO. The block first checks that the requested setting is legal. If it is legal, the block switches the PLL's clock mux to the slow path, which is the 24 MHz oscillator. It then holds the PLL in reset, writes the divider and bandwidth fields, and waits a settle interval. After that it releases reset and samples the lock input at a fixed interval. Once lock is seen, it returns the mux to the PLL output.

An illegal request is rejected at once and nothing is written. A PLL that never locks is abandoned after a set number of samples, with the mux left on the slow path. Both delays are counted in system clock cycles, derived from a parameter that gives the clock frequency in MHz. Computing the divisors belongs to the caller. The analog PLL sits outside the block.

Top module: `pll_reprog_seq`

## Requirements
- R1: A start request in idle is rejected when any of these holds: NR is outside 1..64; NF is outside 1..8192; NO is outside 1..16; NO is odd and not 1; 24·NF is outside 440·NR..2200·NR; 48·NF < 55·NR·NO; or 24·NF > 2200·NR·NO. A rejected request gives a one-cycle `err_o` pulse in the cycle after the start. No other output changes, and the block stays idle.
- R2: An accepted request sets `busy_o` and `mode_slow_o` (1 = slow path) in the cycle after the start. `pll_rst_o` rises one cycle later, and never while the slow path is off.
- R3: One cycle after reset rises, the fields are loaded with the divisor minus one: `ref_fld_o` = NR−1 (6 bits), `fb_fld_o` = NF−1 (13 bits) and `od_fld_o` = NO−1 (4 bits).
- R4: In the same cycle, `bw_fld_o` is loaded with (NF >> 1) − 1, truncated to 12 bits.
- R5: After the fields are loaded, reset stays high for SETTLE_US·CLK_MHZ more cycles. In total it is high for SETTLE_US·CLK_MHZ + 1 cycles.
- R6: After reset falls, `lock_i` is sampled once every POLL_US·CLK_MHZ cycles. The first sample is taken POLL_US·CLK_MHZ cycles after the release.
- R7: At the first sample that finds lock, `mode_slow_o` clears, `busy_o` clears and `done_o` pulses for exactly one cycle.
- R8: If POLL_LIMIT samples in a row miss lock, `err_o` pulses once and `busy_o` clears. `mode_slow_o` stays set, `pll_rst_o` stays low and the fields keep their values.
- R9: A start request, legal or not, has no effect while `busy_o` is set.
- R10: During reset, every output is zero.
- R11: The field outputs change only while `pll_rst_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle reprogramming request |
| nr_i | input | REF_FW+1 | Requested reference divider NR |
| nf_i | input | FB_FW+1 | Requested feedback multiplier NF |
| no_i | input | OD_FW+1 | Requested output divider NO |
| lock_i | input | 1 | Lock indication from the PLL |
| mode_slow_o | output | 1 | 1 selects the oscillator path, 0 the PLL output |
| pll_rst_o | output | 1 | PLL reset control |
| ref_fld_o | output | REF_FW | Reference divider field, NR−1 |
| fb_fld_o | output | FB_FW | Feedback divider field, NF−1 |
| od_fld_o | output | OD_FW | Output divider field, NO−1 |
| bw_fld_o | output | BW_FW | Bandwidth-adjust field, (NF>>1)−1 |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse when the PLL output is selected again |
| err_o | output | 1 | One-cycle pulse on rejection or lock timeout |

## Verification
The main pattern is a sweep over NR 0..8, NO 0..17 and a set of NF values placed on either side of the VCO and output frequency limits. It separates accepted requests from rejected ones for each of the range, parity and frequency conditions. It also checks the field encodings for every triple that is accepted. A second pattern varies the lock latency on both sides of the sample points, which shows whether lock is sampled at the intended period. A third withholds lock entirely, which separates the timeout path from the success path. Start requests issued in the middle of a sequence, one legal and one illegal, show that the latched setting survives.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ARM,
    SQ_LOAD,
    SQ_SETTLE,
    SQ_POLL
  } sq_state_t;

endpackage

// File: rtl/pll_cfg_check.sv
module pll_cfg_check #(
  parameter int REF_FW           = 6,
  parameter int FB_FW            = 13,
  parameter int OD_FW            = 4,
  parameter int OSC_MHZ          = 24,
  parameter int VCO_MIN_MHZ      = 440,
  parameter int VCO_MAX_MHZ      = 2200,
  parameter int OUT_MIN_HALF_MHZ = 55,
  parameter int OUT_MAX_MHZ      = 2200
) (
  input  logic [REF_FW:0] nr_i,
  input  logic [FB_FW:0]  nf_i,
  input  logic [OD_FW:0]  no_i,
  output logic            cfg_ok_o
);

  logic [31:0] nr_w, nf_w, no_w, vco_x, nrno_w;
  logic        range_ok, parity_ok, vco_ok, out_ok;

  assign nr_w   = 32'(nr_i);
  assign nf_w   = 32'(nf_i);
  assign no_w   = 32'(no_i);
  assign vco_x  = 32'(OSC_MHZ) * nf_w;
  assign nrno_w = nr_w * no_w;

  always_comb begin
    range_ok  = (nr_w != 0) && (nr_w <= (32'd1 << REF_FW)) &&
                (nf_w != 0) && (nf_w <= (32'd1 << FB_FW)) &&
                (no_w != 0) && (no_w <= (32'd1 << OD_FW));
    parity_ok = (no_w == 32'd1) || !no_w[0];
    vco_ok    = (vco_x >= 32'(VCO_MIN_MHZ) * nr_w) &&
                (vco_x <= 32'(VCO_MAX_MHZ) * nr_w);
    out_ok    = ((vco_x << 1) >= 32'(OUT_MIN_HALF_MHZ) * nrno_w) &&
                (vco_x <= 32'(OUT_MAX_MHZ) * nrno_w);
    cfg_ok_o  = range_ok && parity_ok && vco_ok && out_ok;
  end

endmodule

// File: rtl/pll_fld_encode.sv
module pll_fld_encode #(
  parameter int REF_FW = 6,
  parameter int FB_FW  = 13,
  parameter int OD_FW  = 4,
  parameter int BW_FW  = 12
) (
  input  logic [REF_FW:0]   nr_i,
  input  logic [FB_FW:0]    nf_i,
  input  logic [OD_FW:0]    no_i,
  output logic [REF_FW-1:0] ref_o,
  output logic [FB_FW-1:0]  fb_o,
  output logic [OD_FW-1:0]  od_o,
  output logic [BW_FW-1:0]  bw_o
);

  // hardware fields hold each divisor minus one
  assign ref_o = REF_FW'(nr_i - 1'b1);
  assign fb_o  = FB_FW'(nf_i - 1'b1);
  assign od_o  = OD_FW'(no_i - 1'b1);
  assign bw_o  = BW_FW'((nf_i >> 1) - 1'b1);

endmodule

// File: rtl/pll_interval_timer.sv
module pll_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int CLK_MHZ    = 250,
  parameter int SETTLE_US  = 10,
  parameter int POLL_US    = 1,
  parameter int POLL_LIMIT = 1000,
  parameter int REF_FW     = 6,
  parameter int FB_FW      = 13,
  parameter int OD_FW      = 4,
  parameter int BW_FW      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [REF_FW:0]   nr_i,
  input  logic [FB_FW:0]    nf_i,
  input  logic [OD_FW:0]    no_i,
  input  logic              lock_i,
  output logic              mode_slow_o,
  output logic              pll_rst_o,
  output logic [REF_FW-1:0] ref_fld_o,
  output logic [FB_FW-1:0]  fb_fld_o,
  output logic [OD_FW-1:0]  od_fld_o,
  output logic [BW_FW-1:0]  bw_fld_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
  localparam int POLL_CYC   = POLL_US * CLK_MHZ;
  localparam int TMR_MAX    = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
  localparam int TMR_W      = $clog2(TMR_MAX) + 1;
  localparam int PCNT_W     = $clog2(POLL_LIMIT) + 1;

  sq_state_t         state_q, state_d;
  logic              mode_q, mode_d, prst_q, prst_d;
  logic              busy_q, busy_d, done_q, done_d, err_q, err_d;
  logic [PCNT_W-1:0] poll_q, poll_d;
  logic              accept, fld_en, tmr_load, tmr_exp, cfg_ok;
  logic [TMR_W-1:0]  tmr_val;

  logic [REF_FW-1:0] ref_enc, ref_stg_q, ref_q;
  logic [FB_FW-1:0]  fb_enc, fb_stg_q, fb_q;
  logic [OD_FW-1:0]  od_enc, od_stg_q, od_q;
  logic [BW_FW-1:0]  bw_enc, bw_stg_q, bw_q;

  pll_cfg_check #(
    .REF_FW(REF_FW), .FB_FW(FB_FW), .OD_FW(OD_FW)
  ) u_check (
    .nr_i(nr_i), .nf_i(nf_i), .no_i(no_i), .cfg_ok_o(cfg_ok)
  );

  pll_fld_encode #(
    .REF_FW(REF_FW), .FB_FW(FB_FW), .OD_FW(OD_FW), .BW_FW(BW_FW)
  ) u_enc (
    .nr_i(nr_i), .nf_i(nf_i), .no_i(no_i),
    .ref_o(ref_enc), .fb_o(fb_enc), .od_o(od_enc), .bw_o(bw_enc)
  );

  pll_interval_timer #(
    .CNT_W(TMR_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
    .expired_o(tmr_exp)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    prst_d   = prst_q;
    busy_d   = busy_q;
    poll_d   = poll_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    accept   = 1'b0;
    fld_en   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          if (cfg_ok) begin
            accept  = 1'b1;
            mode_d  = 1'b1;
            busy_d  = 1'b1;
            state_d = SQ_ARM;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      SQ_ARM: begin
        prst_d  = 1'b1;
        state_d = SQ_LOAD;
      end
      SQ_LOAD: begin
        fld_en   = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(SETTLE_CYC - 1);
        state_d  = SQ_SETTLE;
      end
      SQ_SETTLE: begin
        if (tmr_exp) begin
          prst_d   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(POLL_CYC - 1);
          poll_d   = '0;
          state_d  = SQ_POLL;
        end
      end
      SQ_POLL: begin
        if (tmr_exp) begin
          if (lock_i) begin
            mode_d  = 1'b0;
            done_d  = 1'b1;
            busy_d  = 1'b0;
            state_d = SQ_IDLE;
          end else if (poll_q == PCNT_W'(POLL_LIMIT - 1)) begin
            err_d   = 1'b1;
            busy_d  = 1'b0;
            state_d = SQ_IDLE;
          end else begin
            poll_d   = poll_q + 1'b1;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(POLL_CYC - 1);
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      mode_q  <= 1'b0;
      prst_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      poll_q  <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      prst_q  <= prst_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      err_q   <= err_d;
      poll_q  <= poll_d;
    end
  end

  // staged encodings, captured on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_stg_q <= '0;
      fb_stg_q  <= '0;
      od_stg_q  <= '0;
      bw_stg_q  <= '0;
    end else if (accept) begin
      ref_stg_q <= ref_enc;
      fb_stg_q  <= fb_enc;
      od_stg_q  <= od_enc;
      bw_stg_q  <= bw_enc;
    end
  end

  // field outputs, written only in the programming step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      fb_q  <= '0;
      od_q  <= '0;
      bw_q  <= '0;
    end else if (fld_en) begin
      ref_q <= ref_stg_q;
      fb_q  <= fb_stg_q;
      od_q  <= od_stg_q;
      bw_q  <= bw_stg_q;
    end
  end

  assign mode_slow_o = mode_q;
  assign pll_rst_o   = prst_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign ref_fld_o   = ref_q;
  assign fb_fld_o    = fb_q;
  assign od_fld_o    = od_q;
  assign bw_fld_o    = bw_q;

  AST_SLOW_BEFORE_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_rst_o) |-> $past(mode_slow_o)); // R2

  AST_RST_NEEDS_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst_o |-> mode_slow_o); // R2

  AST_FIELDS_UNDER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ref_fld_o, fb_fld_o, od_fld_o, bw_fld_o}) |-> pll_rst_o); // R11

  AST_DONE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(lock_i) && !pll_rst_o && !mode_slow_o); // R7

  AST_NORMAL_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_slow_o) |-> done_o); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o)); // R1

  AST_TIMEOUT_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && $past(busy_o) |-> mode_slow_o && !pll_rst_o && !busy_o); // R8

endmodule

// File: tb/test_pll_reprog_seq.sv
module test_pll_reprog_seq;

  localparam int MHZ = 4;
  localparam int LIM = 8;
  localparam int S   = 10 * MHZ;
  localparam int P   = 1 * MHZ;

  logic        clk, rst_n, start, lock;
  logic [6:0]  nr;
  logic [13:0] nf;
  logic [4:0]  no;
  logic        mode_slow, pll_rst, busy, done, err;
  logic [5:0]  ref_fld;
  logic [12:0] fb_fld;
  logic [3:0]  od_fld;
  logic [11:0] bw_fld;

  int n_chk, n_err;
  int lock_dly;
  bit lock_en;
  int lk_cnt;

  pll_reprog_seq #(
    .CLK_MHZ(MHZ), .SETTLE_US(10), .POLL_US(1), .POLL_LIMIT(LIM)
  ) i_pll_reprog_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .nr_i(nr), .nf_i(nf),
    .no_i(no), .lock_i(lock), .mode_slow_o(mode_slow), .pll_rst_o(pll_rst),
    .ref_fld_o(ref_fld), .fb_fld_o(fb_fld), .od_fld_o(od_fld),
    .bw_fld_o(bw_fld), .busy_o(busy), .done_o(done), .err_o(err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // PLL stand-in: lock rises lock_dly cycles after reset is released
  always @(posedge clk) begin
    if (!lock_en || pll_rst) begin
      lk_cnt <= 0;
      lock   <= 1'b0;
    end else if (lk_cnt >= lock_dly - 1) begin
      lock <= 1'b1;
    end else begin
      lk_cnt <= lk_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_valid(input int a, input int f, input int o);
    if (a < 1 || a > 64 || f < 1 || f > 8192 || o < 1 || o > 16) return 1'b0;
    if (o != 1 && (o % 2) != 0) return 1'b0;
    return (24 * f >= 440 * a) && (24 * f <= 2200 * a) &&
           (48 * f >= 55 * a * o) && (24 * f <= 2200 * a * o);
  endfunction

  task automatic run_cfg(input int a, input int f, input int o, input int lat,
                         input bit le, input bit inj);
    bit v;
    bit p_mode;
    logic [34:0] p_fld, e_fld;
    int rh, j, ej;
    v      = exp_valid(a, f, o);
    p_mode = mode_slow;
    p_fld  = {ref_fld, fb_fld, od_fld, bw_fld};
    e_fld  = {6'(a - 1), 13'(f - 1), 4'(o - 1), 12'((f >> 1) - 1)};
    @(negedge clk);
    start = 1'b1; nr = 7'(a); nf = 14'(f); no = 5'(o);
    lock_dly = lat; lock_en = le;
    @(negedge clk);
    start = 1'b0;
    chk(err == !v, "R1 accept/reject", err, !v);
    if (!v) begin
      chk(!busy && mode_slow == p_mode && !pll_rst &&
          {ref_fld, fb_fld, od_fld, bw_fld} == p_fld, "R1 no effect",
          {busy, pll_rst}, 0);
      @(negedge clk);
      chk(!err, "R1 err single pulse", err, 0);
      return;
    end
    chk(busy && mode_slow && !pll_rst, "R2 slow first", {busy, mode_slow, pll_rst}, 3'b110);
    @(negedge clk);
    chk(pll_rst && {ref_fld, fb_fld, od_fld, bw_fld} == p_fld, "R2 reset before fields",
        pll_rst, 1);
    @(negedge clk);
    chk({ref_fld, fb_fld, od_fld} == e_fld[34:12], "R3 divider fields",
        {ref_fld, fb_fld, od_fld}, e_fld[34:12]);
    chk(bw_fld == e_fld[11:0], "R4 bandwidth field", bw_fld, e_fld[11:0]);
    rh = 2;
    if (inj) begin
      start = 1'b1; nr = 7'd3; nf = 14'd100; no = 5'd2;
      @(negedge clk);
      start = 1'b0; rh++;
      chk(!err && {ref_fld, fb_fld, od_fld, bw_fld} == e_fld, "R9 legal start while busy",
          ref_fld, e_fld[34:29]);
      start = 1'b1; nr = 7'd0;
      @(negedge clk);
      start = 1'b0; rh++;
      chk(!err && busy, "R9 illegal start while busy", err, 0);
    end
    while (rh < 10000) begin
      @(negedge clk);
      if (pll_rst) rh++;
      else break;
    end
    chk(rh == S + 1, "R5 reset hold", rh, S + 1);
    j = 0;
    while (!done && !err && j < 5000) begin
      @(negedge clk);
      j++;
    end
    ej = P * ((lat + P) / P);
    if (le && ej <= P * LIM) begin
      chk(done && j == ej, "R6 lock sample point", j, ej);
      chk(!mode_slow && !busy && !err, "R7 normal restored", {mode_slow, busy}, 0);
      chk({ref_fld, fb_fld, od_fld, bw_fld} == e_fld, "R11 fields held", ref_fld, e_fld[34:29]);
    end else begin
      chk(err && j == P * LIM, "R8 timeout point", j, P * LIM);
      chk(mode_slow && !pll_rst && !busy && !done &&
          {ref_fld, fb_fld, od_fld, bw_fld} == e_fld, "R8 left slow",
          {mode_slow, pll_rst, busy}, 3'b100);
    end
    @(negedge clk);
    chk(!done && !err, "R7 single pulse", {done, err}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    start = 1'b0; nr = '0; nf = '0; no = '0;
    lock_dly = 2; lock_en = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({mode_slow, pll_rst, busy, done, err} == 0 &&
        {ref_fld, fb_fld, od_fld, bw_fld} == 0, "R10 reset state",
        {mode_slow, pll_rst, busy, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep across range, parity and frequency limits
    for (int a = 0; a <= 8; a++) begin
      for (int o = 0; o <= 17; o++) begin
        foreach (nf_set[k]) run_cfg(a, nf_set[k], o, 2, 1'b1, 1'b0);
      end
    end

    // reference divider field edge
    run_cfg(64, 1200, 2, 2, 1'b1, 1'b0);
    run_cfg(65, 1200, 2, 2, 1'b1, 1'b0);

    // lock latency around sample points
    run_cfg(1, 50, 2, 3, 1'b1, 1'b0);
    run_cfg(1, 50, 2, 4, 1'b1, 1'b0);
    run_cfg(1, 50, 2, 5, 1'b1, 1'b0);
    run_cfg(2, 100, 4, 9, 1'b1, 1'b0);

    // lock never arrives, then recovery
    run_cfg(1, 60, 2, 2, 1'b0, 1'b0);
    run_cfg(3, 0, 2, 2, 1'b1, 1'b0);
    run_cfg(1, 70, 1, 2, 1'b1, 1'b0);

    // start requests during a sequence
    run_cfg(2, 80, 4, 2, 1'b1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  int nf_set[14] = '{0, 1, 18, 19, 37, 55, 73, 91, 92, 110, 183, 366, 550, 733};

endmodule